// File: doc/BRIEF.md
# Hex Record Line Checksum Verifier

This block checks one text line of a hex record file as its ASCII characters stream in, one character per accepted cycle. It recognises the leading record marker, decodes the record type digit, turns hex character pairs into bytes, and splits those bytes into a length, a type-dependent address and a run of payload bytes. It keeps a running byte sum as it goes. It compares the final byte of the line with the one's complement of the low eight bits of that sum.

The record type, the length, the assembled address and each payload byte appear on their own valid-qualified outputs as soon as the character that completes them is accepted. This lets a downstream loader consume the record while it is still arriving. A single result pulse per line carries a status code that gives either the verdict or the kind of malformation found. A per-line restart input begins a new line, and the character presented with it is taken as that line's first character.

Top module: `srec_line_checker`

## Requirements
- R1: After reset, and before any character is accepted, type_valid, len_valid, addr_valid, data_valid and res_valid are all low.
- R2: If the first character of a line is not uppercase 'S' (0x53), a result with code 1 (format) is issued for that character.
- R3: The second character must be an ASCII digit. A digit is reported on rec_type (value 0 to 9) with type_valid. A non-digit gives code 1 and no type_valid. Digits 4 and 6 give type_valid together with result code 3 (unsupported type).
- R4: The address is 2 bytes for types 0, 1, 5 and 9, 3 bytes for types 2 and 8, and 4 bytes for types 3 and 7. It is assembled most significant byte first, zero-extended, and reported with addr_valid when its last byte completes.
- R5: The first byte after the type is the length, counting the address, payload and checksum bytes. It is reported with len_valid. A length below the address size plus one gives result code 4 (short) in the same cycle.
- R6: The bytes between the address and the last byte are payload. They are reported in order on data_byte with data_valid, and there are length minus address size minus one of them.
- R7: The last byte passes (code 0) when it equals 0xFF minus the low byte of the sum of the length, address and payload bytes, and fails with code 2 otherwise. The line S11317C0C046C046C046C046FFF766FF1C1814104A passes.
- R8: Hex digits 0-9, A-F and a-f are all accepted. Any other character inside a hex field gives code 1.
- R9: If in_last is set on any character before the second character of the checksum byte, a result with code 5 (early end) is issued for that character.
- R10: Each line yields at most one result. Characters after the result produce no output until line_start.
- R11: line_start restarts parsing, and the character accepted in the same cycle is treated as the first character of the new line.
- R12: Every output pulse lasts one cycle and appears in the cycle right after the character that completes it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Begin a new line; the same-cycle character is its first |
| in_valid | input | 1 | A character is presented |
| in_char | input | 8 | ASCII character |
| in_last | input | 1 | Presented character ends the line |
| type_valid | output | 1 | Record type decoded |
| rec_type | output | 4 | Record type digit value |
| len_valid | output | 1 | Length byte decoded |
| rec_len | output | 8 | Length byte |
| addr_valid | output | 1 | Address fully assembled |
| rec_addr | output | ADDR_W | Zero-extended address |
| data_valid | output | 1 | Payload byte decoded |
| data_byte | output | 8 | Payload byte |
| res_valid | output | 1 | Line verdict issued |
| res_code | output | 3 | 0 pass, 1 format, 2 checksum, 3 unsupported, 4 short, 5 early end |

## Verification
Several functions can fire in the same cycle. A field can complete on the very character that also yields the line's verdict: the length together with a short verdict, the type digit together with an unsupported verdict, or the last address byte together with an early end. A line restart can also arrive with the character that begins the new line. The bench provokes each case on purpose: it ends a line exactly on the last address character, sends short and unsupported records, aborts a half-received line by restarting with a new 'S', and sends every line with its restart on the first character. The scoreboard holds the field and verdict items of one cycle in a fixed order, so both pulses must appear in that one cycle with the right values.

// File: rtl/srec_pkg.sv
package srec_pkg;

    localparam logic [7:0] CHAR_MARK = 8'h53;

    typedef enum logic [1:0] {
        ST_MARK = 2'd0,
        ST_TYPE = 2'd1,
        ST_HEX  = 2'd2,
        ST_HOLD = 2'd3
    } srec_stage_t;

    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_FORMAT = 3'd1,
        RES_SUM    = 3'd2,
        RES_UNSUP  = 3'd3,
        RES_SHORT  = 3'd4,
        RES_EARLY  = 3'd5
    } srec_res_t;

endpackage

// File: rtl/srec_hex_nibble.sv
module srec_hex_nibble (
    input  logic [7:0] ch,
    output logic       ok,
    output logic [3:0] nib
);
    always_comb begin
        ok  = 1'b1;
        nib = 4'd0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            nib = ch[3:0];
        end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
            nib = ch[3:0] + 4'd9;
        end else begin
            ok = 1'b0;
        end
    end
endmodule

// File: rtl/srec_type_decode.sv
module srec_type_decode (
    input  logic [7:0] ch,
    output logic       is_digit,
    output logic       supported,
    output logic [3:0] code,
    output logic [2:0] addr_bytes
);
    always_comb begin
        is_digit = (ch >= 8'h30) && (ch <= 8'h39);
        code     = ch[3:0];
        unique case (code)
            4'd0, 4'd1, 4'd5, 4'd9: addr_bytes = 3'd2;
            4'd2, 4'd8:             addr_bytes = 3'd3;
            4'd3, 4'd7:             addr_bytes = 3'd4;
            default:                addr_bytes = 3'd0;
        endcase
        supported = is_digit && (addr_bytes != 3'd0);
    end
endmodule

// File: rtl/srec_sum_acc.sv
module srec_sum_acc #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] val,
    output logic [W-1:0] sum
);
    logic [W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add) begin
            sum_d = sum_q + val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/srec_line_checker.sv
module srec_line_checker
    import srec_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    input  logic              in_last,
    output logic              type_valid,
    output logic [3:0]        rec_type,
    output logic              len_valid,
    output logic [7:0]        rec_len,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              data_valid,
    output logic [7:0]        data_byte,
    output logic              res_valid,
    output logic [2:0]        res_code
);
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IDX_W  = 3;

    typedef struct packed {
        srec_stage_t        stage;
        logic               hi_have;
        logic [3:0]         hi_nib;
        logic               len_seen;
        logic [BYTE_W-1:0]  left;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   asz;
        logic [ADDR_W-1:0]  addr;
        logic               type_v;
        logic [3:0]         rtype;
        logic               len_v;
        logic [BYTE_W-1:0]  len;
        logic               addr_v;
        logic               data_v;
        logic [BYTE_W-1:0]  data;
        logic               res_v;
        srec_res_t          res;
    } state_t;

    state_t d, q;

    logic              hx_ok;
    logic [3:0]        hx_nib;
    logic              ty_digit;
    logic              ty_sup;
    logic [3:0]        ty_code;
    logic [IDX_W-1:0]  ty_asz;
    logic              sum_clr;
    logic              sum_add;
    logic [BYTE_W-1:0] sum_val;
    logic [BYTE_W-1:0] sum_q;
    logic [BYTE_W-1:0] byte_val;

    srec_hex_nibble i_hex (
        .ch  (in_char),
        .ok  (hx_ok),
        .nib (hx_nib)
    );

    srec_type_decode i_type (
        .ch         (in_char),
        .is_digit   (ty_digit),
        .supported  (ty_sup),
        .code       (ty_code),
        .addr_bytes (ty_asz)
    );

    srec_sum_acc #(.W(BYTE_W)) i_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .add   (sum_add),
        .val   (sum_val),
        .sum   (sum_q)
    );

    function automatic state_t finish(input state_t s, input srec_res_t c);
        state_t r;
        r       = s;
        r.res_v = 1'b1;
        r.res   = c;
        r.stage = ST_HOLD;
        return r;
    endfunction

    assign byte_val = {q.hi_nib, hx_nib};
    assign sum_val  = byte_val;

    always_comb begin
        d        = q;
        d.type_v = 1'b0;
        d.len_v  = 1'b0;
        d.addr_v = 1'b0;
        d.data_v = 1'b0;
        d.res_v  = 1'b0;
        sum_clr  = line_start;
        sum_add  = 1'b0;

        if (line_start) begin
            d.stage    = ST_MARK;
            d.hi_have  = 1'b0;
            d.len_seen = 1'b0;
            d.idx      = '0;
            d.left     = '0;
            d.addr     = '0;
        end

        if (in_valid) begin
            unique case (d.stage)
                ST_MARK: begin
                    if (in_char != CHAR_MARK)  d = finish(d, RES_FORMAT);
                    else if (in_last)          d = finish(d, RES_EARLY);
                    else                       d.stage = ST_TYPE;
                end
                ST_TYPE: begin
                    if (!ty_digit) begin
                        d = finish(d, RES_FORMAT);
                    end else begin
                        d.type_v = 1'b1;
                        d.rtype  = ty_code;
                        d.asz    = ty_asz;
                        if (!ty_sup)      d = finish(d, RES_UNSUP);
                        else if (in_last) d = finish(d, RES_EARLY);
                        else              d.stage = ST_HEX;
                    end
                end
                ST_HEX: begin
                    if (!hx_ok) begin
                        d = finish(d, RES_FORMAT);
                    end else if (!d.hi_have) begin
                        d.hi_have = 1'b1;
                        d.hi_nib  = hx_nib;
                        if (in_last) d = finish(d, RES_EARLY);
                    end else begin
                        d.hi_have = 1'b0;
                        if (!d.len_seen) begin
                            d.len_v = 1'b1;
                            d.len   = byte_val;
                            if (byte_val < ({5'd0, d.asz} + 8'd1)) begin
                                d = finish(d, RES_SHORT);
                            end else begin
                                d.len_seen = 1'b1;
                                d.left     = byte_val;
                                sum_add    = 1'b1;
                                if (in_last) d = finish(d, RES_EARLY);
                            end
                        end else if (d.idx < d.asz) begin
                            d.addr  = {d.addr[ADDR_W-BYTE_W-1:0], byte_val};
                            d.idx   = d.idx + 1'b1;
                            d.left  = d.left - 1'b1;
                            sum_add = 1'b1;
                            if (d.idx == d.asz) d.addr_v = 1'b1;
                            if (in_last) d = finish(d, RES_EARLY);
                        end else if (d.left == 8'd1) begin
                            d.left = '0;
                            if (byte_val == ~sum_q) d = finish(d, RES_OK);
                            else                    d = finish(d, RES_SUM);
                        end else begin
                            d.data_v = 1'b1;
                            d.data   = byte_val;
                            d.left   = d.left - 1'b1;
                            sum_add  = 1'b1;
                            if (in_last) d = finish(d, RES_EARLY);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= state_t'('0);
        else        q <= d;
    end

    assign type_valid = q.type_v;
    assign rec_type   = q.rtype;
    assign len_valid  = q.len_v;
    assign rec_len    = q.len;
    assign addr_valid = q.addr_v;
    assign rec_addr   = q.addr;
    assign data_valid = q.data_v;
    assign data_byte  = q.data;
    assign res_valid  = q.res_v;
    assign res_code   = q.res;
endmodule

// File: rtl/srec_line_checker_sva.sv
module srec_line_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       in_valid,
    input logic       type_valid,
    input logic [3:0] rec_type,
    input logic       len_valid,
    input logic       addr_valid,
    input logic       data_valid,
    input logic       res_valid,
    input logic [2:0] res_code
);
    a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !line_start) |=> !res_valid);

    a_r6_addr_data_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid, data_valid}));

    a_r12_pulse_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
        (type_valid || len_valid || addr_valid || data_valid || res_valid) |-> $past(in_valid));

    a_r3_type_is_digit: assert property (@(posedge clk) disable iff (!rst_n)
        type_valid |-> (rec_type <= 4'd9));

    a_r5_short_with_len: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 3'd4) |-> len_valid);

    a_r3_unsup_with_type: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == 3'd3) |-> type_valid);
endmodule

bind srec_line_checker srec_line_checker_sva i_srec_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .in_valid   (in_valid),
    .type_valid (type_valid),
    .rec_type   (rec_type),
    .len_valid  (len_valid),
    .addr_valid (addr_valid),
    .data_valid (data_valid),
    .res_valid  (res_valid),
    .res_code   (res_code)
);

// File: tb/test_srec_line_checker.sv
`timescale 1ns/1ps
module test_srec_line_checker;
    localparam int unsigned ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_start = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_char = 8'h00;
    logic              in_last = 1'b0;
    logic              type_valid, len_valid, addr_valid, data_valid, res_valid;
    logic [3:0]        rec_type;
    logic [7:0]        rec_len, data_byte;
    logic [ADDR_W-1:0] rec_addr;
    logic [2:0]        res_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] val;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    srec_line_checker #(.ADDR_W(ADDR_W)) i_srec_line_checker (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
        .in_char(in_char), .in_last(in_last), .type_valid(type_valid), .rec_type(rec_type),
        .len_valid(len_valid), .rec_len(rec_len), .addr_valid(addr_valid), .rec_addr(rec_addr),
        .data_valid(data_valid), .data_byte(data_byte), .res_valid(res_valid), .res_code(res_code)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] val, input string tag);
        item_t it;
        it.kind = kind; it.val = val; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic observe(input int kind, input logic [31:0] val);
        item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, $sformatf("R10 unexpected output kind %0d", kind), val, 32'hFFFF_FFFF);
        end else begin
            it = exp_q.pop_front();
            check(it.kind == kind && it.val == val,
                  $sformatf("%s kind %0d/%0d", it.tag, kind, it.kind), val, it.val);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (type_valid) observe(0, {28'd0, rec_type});
            if (len_valid)  observe(1, {24'd0, rec_len});
            if (addr_valid) observe(2, rec_addr);
            if (data_valid) observe(3, {24'd0, data_byte});
            if (res_valid)  observe(4, {29'd0, res_code});
        end
    end

    function automatic logic [3:0] nib(input byte c);
        if (c <= 8'h39) return c[3:0];
        return c[3:0] + 4'd9;
    endfunction

    function automatic logic [7:0] hx(input string s, input int i);
        return {nib(s[i]), nib(s[i+1])};
    endfunction

    function automatic int asz_of(input int t);
        case (t)
            0, 1, 5, 9: return 2;
            2, 8:       return 3;
            default:    return 4;
        endcase
    endfunction

    // Expectations for a complete, well-formed line (R3, R4, R5, R6, R7)
    task automatic expect_full(input string s);
        int t, asz, len, pos;
        logic [7:0]  sum, cs;
        logic [31:0] a;
        t   = s[1] - 8'h30;
        asz = asz_of(t);
        len = hx(s, 2);
        push(0, t, "R3 type");
        push(1, len, "R5 length");
        sum = len[7:0];
        a = 0;
        pos = 4;
        for (int i = 0; i < asz; i++) begin
            a = (a << 8) | hx(s, pos);
            sum = sum + hx(s, pos);
            pos += 2;
        end
        push(2, a, "R4 address");
        for (int i = 0; i < len - asz - 1; i++) begin
            push(3, hx(s, pos), "R6 payload");
            sum = sum + hx(s, pos);
            pos += 2;
        end
        cs = hx(s, pos);
        push(4, (cs == (8'hFF - sum)) ? 0 : 2, "R7 verdict");
    endtask

    task automatic send(input string s, input bit start, input bit last_at_end);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            line_start = start && (i == 0);
            in_valid   = 1'b1;
            in_char    = s[i];
            in_last    = last_at_end && (i == s.len() - 1);
        end
        @(negedge clk);
        line_start = 1'b0;
        in_valid   = 1'b0;
        in_last    = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "watchdog expired", 0, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string ex;
        ex = "S11317C0C046C046C046C046FFF766FF1C1814104A";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({type_valid, len_valid, addr_valid, data_valid, res_valid} == 5'b0,
              "R1 reset outputs", {type_valid, len_valid, addr_valid, data_valid, res_valid}, 0);

        // R7, R11 (restart with first char), R12 (verdict the cycle after the last char)
        expect_full(ex);
        send(ex, 1'b1, 1'b1);
        check(res_valid === 1'b1 && res_code == 3'd0, "R12 verdict timing", {res_valid, res_code}, 4'b1000);

        // R10: trailing characters ignored
        send("ZZ00", 1'b0, 1'b1);
        check(res_valid === 1'b0, "R10 trailing ignored", res_valid, 0);

        // R8 lowercase hex
        expect_full("S11317c0c046c046c046c046fff766ff1c1814104a");
        send("S11317c0c046c046c046c046fff766ff1c1814104a", 1'b1, 1'b1);

        // R7 bad checksum
        expect_full("S11317C0C046C046C046C046FFF766FF1C1814104B");
        send("S11317C0C046C046C046C046FFF766FF1C1814104B", 1'b1, 1'b1);

        // R4 address sizes over all supported types
        expect_full("S205123456ABB3");         send("S205123456ABB3", 1'b1, 1'b1);
        expect_full("S30500010203F4");         send("S30500010203F4", 1'b1, 1'b1);
        expect_full("S00600004844521B");       send("S00600004844521B", 1'b1, 1'b1);
        expect_full("S5030003F9");             send("S5030003F9", 1'b1, 1'b1);
        expect_full("S70500000000FA");         send("S70500000000FA", 1'b1, 1'b1);
        expect_full("S804000000FB");           send("S804000000FB", 1'b1, 1'b1);
        expect_full("S9030000FC");             send("S9030000FC", 1'b1, 1'b1);

        // R2 bad first char, rest ignored
        push(4, 1, "R2 bad marker");
        send("X1030000FC", 1'b1, 1'b1);

        // R3 unsupported types and non-digit
        push(0, 4, "R3 type 4"); push(4, 3, "R3 unsupported 4");
        send("S4030000FC", 1'b1, 1'b1);
        push(0, 6, "R3 type 6"); push(4, 3, "R3 unsupported 6");
        send("S6030000FC", 1'b1, 1'b1);
        push(4, 1, "R3 non-digit type");
        send("SA030000FC", 1'b1, 1'b1);

        // R5 short length, same cycle as length
        push(0, 1, "R5 type"); push(1, 2, "R5 short length"); push(4, 4, "R5 short verdict");
        send("S10200FD", 1'b1, 1'b1);

        // R8 non-hex inside a field
        push(0, 1, "R8 type"); push(4, 1, "R8 non-hex");
        send("S1G30000FC", 1'b1, 1'b1);

        // R9 early end on last address char, and on a high nibble
        push(0, 1, "R9 type"); push(1, 5, "R9 length"); push(2, 32'h1234, "R9 address");
        push(4, 5, "R9 early on address");
        send("S1051234", 1'b1, 1'b1);
        push(0, 1, "R9 type b"); push(4, 5, "R9 early on nibble");
        send("S11", 1'b1, 1'b1);

        // R11 abort a half line with a restart
        push(0, 1, "R11 type"); push(1, 8'h13, "R11 length");
        send("S1131", 1'b1, 1'b0);
        expect_full("S9030000FC");
        send("S9030000FC", 1'b1, 1'b1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R10 all expected outputs seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule